// File: doc/BRIEF.md
# Serial Input Frame Offset Aligner

This block is the receive front end of a multi-stream time-division serial switch. It watches a shared frame pulse and a group of serial data inputs. For each stream it waits a programmable delay after the frame pulse before counting local time from zero, samples every bit cell at one chosen point, and packs the bits into bytes. Each completed byte leaves on its own stream lane with a one-cycle valid strobe and its channel index within the frame. The lane position is the stream number.

`clk_i` runs at twice the serial bit clock, so one `clk_i` cycle is half a bit-clock period. A bit cell spans two bit-clock periods, which is four `clk_i` cycles. Local cycle 3 of a cell is the rising bit-clock edge at the three-quarter point, and local cycle 2 is the falling edge just before it. Per-stream delay and edge fields sit in 16-bit words that software writes. They, and the framing mode input, are adopted only when a frame pulse arrives.

Top module: `tsi_rx_align`

## Requirements
- R1: After `rst_ni` is released, every configuration word reads 0x0000 and no lane raises `byte_vld_o` until a frame pulse has been seen.
- R2: Word w holds streams 4w to 4w+3. Stream s uses bits [4(s%4)+3 : 4(s%4)]: bit 0 of the nibble is the edge bit and bits 3:1 are the delay code. A read returns the last value written, a read of an unused address returns 0, and a write to an unused address changes nothing.
- R3: Take the `clk_i` edge that samples `fp_i` high as edge 0. With delay code k, frame bit b of a stream is sampled at edge k+1+4b+p, where p is the sampling slot.
- R4: With `mode_i`=0, edge bit 0 selects the rising edge (p=3) and edge bit 1 selects the falling edge (p=2).
- R5: With `mode_i`=1 the edge bit is inverted: 0 selects p=2 and 1 selects p=3.
- R6: The first bit of a byte becomes its MSB. `byte_vld_o[s]` pulses for one cycle after the edge that samples the byte's eighth bit, with the byte on `byte_data_o[8s+7:8s]` and channel b/8 on its `byte_chan_o` slice.
- R7: Register writes and `mode_i` changes take effect only at the next frame pulse. A frame in progress finishes with the values latched at its own pulse.
- R8: After N_CHAN bytes a lane goes idle and emits nothing more until the next frame pulse.
- R9: A frame pulse during a frame restarts every lane's alignment from the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the serial bit-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse, one cycle high |
| mode_i | input | 1 | Framing mode: 0 rising-default, 1 inverted edge meaning |
| rx_i | input | N_STREAMS | Serial data, one bit per stream |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_addr_i | input | AW | Configuration word address |
| reg_wdata_i | input | 16 | Configuration write data |
| reg_rdata_o | output | 16 | Configuration read data for `reg_addr_i` |
| byte_vld_o | output | N_STREAMS | Byte strobe per stream lane |
| byte_data_o | output | 8*N_STREAMS | Assembled byte per lane |
| byte_chan_o | output | CH_W*N_STREAMS | Channel index per lane |

## Verification
A wrong delay or sampling slot moves the capture point by at least one `clk_i` cycle. The bench drives the true bit only in the expected slot and the inverted bit in every other slot, so the first byte of the frame, about 30 cycles after the pulse, comes out corrupted or with its strobe one cycle off. A wrong configuration latch shows up in the frame that follows a write made mid-frame. A lane that fails to stop raises a stray strobe soon after the frame's last byte.

// File: rtl/tsi_rx_pkg.sv
package tsi_rx_pkg;
  localparam int OFF_W    = 3;
  localparam int MAX_OFF  = (1 << OFF_W) - 1;
  localparam int BYTE_W   = 8;
  localparam int SLOT_W   = 2;                  // 4 half periods per bit cell
  localparam int BIT_SH   = SLOT_W + 3;         // slot + bit-in-byte
  localparam int REG_W    = 16;
  localparam int PER_REG  = REG_W / (OFF_W + 1);

  typedef struct packed {
    logic [OFF_W-1:0] off;
    logic             dle;
  } lane_cfg_t;
endpackage

// File: rtl/tsi_rx_cfg.sv
module tsi_rx_cfg
  import tsi_rx_pkg::*;
#(
  parameter int N_STREAMS = 4,
  localparam int N_REGS = (N_STREAMS + PER_REG - 1) / PER_REG,
  localparam int AW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fp_i,
  input  logic                       mode_i,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           rdata_o,
  output lane_cfg_t [N_STREAMS-1:0]  shadow_o,
  output lane_cfg_t [N_STREAMS-1:0]  active_o,
  output logic                       gci_o
);
  logic [REG_W-1:0] shadow_q [N_REGS];
  lane_cfg_t [N_STREAMS-1:0] active_q;
  logic gci_q;

  for (genvar w = 0; w < N_REGS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        shadow_q[w] <= '0;
      else if (we_i && addr_i == AW'(w))  shadow_q[w] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < N_REGS; w++)
      if (addr_i == AW'(w)) rdata_o = shadow_q[w];
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_map
    assign shadow_o[s] = shadow_q[s / PER_REG][(s % PER_REG) * (OFF_W + 1) +: (OFF_W + 1)];
  end

  // frame-boundary adoption
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      gci_q    <= 1'b0;
    end else if (fp_i) begin
      active_q <= shadow_o;
      gci_q    <= mode_i;
    end
  end

  assign active_o = active_q;
  assign gci_o    = gci_q;

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> ($stable(active_q) && $stable(gci_q)));
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane
  import tsi_rx_pkg::*;
#(
  parameter int N_CHAN = 8,
  localparam int FRAME_CYC = N_CHAN * BYTE_W * (1 << SLOT_W),
  localparam int POS_W = $clog2(FRAME_CYC + 1),
  localparam int CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fp_i,
  input  logic [MAX_OFF-1:0]  fp_hist_i,
  input  lane_cfg_t           shadow_i,
  input  lane_cfg_t           cfg_i,
  input  logic                gci_i,
  input  logic                rx_i,
  output logic                vld_o,
  output logic [BYTE_W-1:0]   data_o,
  output logic [CH_W-1:0]     chan_o
);
  logic [MAX_OFF:0]    fp_taps;
  logic                start, running, rise, hit, last_bit;
  logic [SLOT_W-1:0]   samp_slot;
  logic [POS_W-1:0]    pos_q;
  logic [BYTE_W-1:0]   sr_q, sr_next;
  logic                vld_q;
  logic [BYTE_W-1:0]   data_q;
  logic [CH_W-1:0]     chan_q;

  assign fp_taps = {fp_hist_i, fp_i};
  // code 0 starts on the pulse edge itself, using the value being adopted there
  assign start = (fp_i && shadow_i.off == '0) ||
                 (cfg_i.off != '0 && fp_taps[cfg_i.off]);

  assign running   = pos_q != POS_W'(FRAME_CYC);
  assign rise      = ~(cfg_i.dle ^ gci_i);
  assign samp_slot = rise ? SLOT_W'(3) : SLOT_W'(2);
  assign hit       = running && (pos_q[SLOT_W-1:0] == samp_slot);
  assign last_bit  = &pos_q[BIT_SH-1:SLOT_W];
  assign sr_next   = {sr_q[BYTE_W-2:0], rx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= POS_W'(FRAME_CYC);
    else if (start)   pos_q <= '0;
    else if (running) pos_q <= POS_W'(pos_q + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      chan_q <= '0;
    end else begin
      vld_q <= hit && last_bit;
      if (hit) sr_q <= sr_next;
      if (hit && last_bit) begin
        data_q <= sr_next;
        chan_q <= CH_W'(pos_q >> BIT_SH);
      end
    end
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;
  assign chan_o = chan_q;

  assert_start_after_fp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (fp_i || (|fp_hist_i)));
  assert_byte_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !start) |=> !vld_q);
endmodule

// File: rtl/tsi_rx_align.sv
module tsi_rx_align
  import tsi_rx_pkg::*;
#(
  parameter int N_STREAMS = 4,
  parameter int N_CHAN = 8,
  localparam int N_REGS = (N_STREAMS + PER_REG - 1) / PER_REG,
  localparam int AW = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fp_i,
  input  logic                        mode_i,
  input  logic [N_STREAMS-1:0]        rx_i,
  input  logic                        reg_we_i,
  input  logic [AW-1:0]               reg_addr_i,
  input  logic [REG_W-1:0]            reg_wdata_i,
  output logic [REG_W-1:0]            reg_rdata_o,
  output logic [N_STREAMS-1:0]        byte_vld_o,
  output logic [N_STREAMS*BYTE_W-1:0] byte_data_o,
  output logic [N_STREAMS*CH_W-1:0]   byte_chan_o
);
  lane_cfg_t [N_STREAMS-1:0] shadow, active;
  logic gci;
  logic [MAX_OFF-1:0] fp_hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_hist_q <= '0;
    else         fp_hist_q <= {fp_hist_q[MAX_OFF-2:0], fp_i};
  end

  tsi_rx_cfg #(.N_STREAMS(N_STREAMS)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fp_i     (fp_i),
    .mode_i   (mode_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .shadow_o (shadow),
    .active_o (active),
    .gci_o    (gci)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
    tsi_rx_lane #(.N_CHAN(N_CHAN)) i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fp_i      (fp_i),
      .fp_hist_i (fp_hist_q),
      .shadow_i  (shadow[s]),
      .cfg_i     (active[s]),
      .gci_i     (gci),
      .rx_i      (rx_i[s]),
      .vld_o     (byte_vld_o[s]),
      .data_o    (byte_data_o[s*BYTE_W +: BYTE_W]),
      .chan_o    (byte_chan_o[s*CH_W +: CH_W])
    );
  end
endmodule

// File: tb/test_tsi_rx_align.sv
module test_tsi_rx_align;
  localparam int NS = 4;
  localparam int NC = 8;
  localparam int CH_W = 3;
  localparam int FRAME_CYC = NC * 32;

  // cfg word, mode, pattern
  localparam logic [24:0] VEC [6] = '{
    {16'h6420, 1'b0, 8'h3C},
    {16'hFDB9, 1'b0, 8'hA7},
    {16'h4B0F, 1'b1, 8'h5E},
    {16'h92D6, 1'b1, 8'h01},
    {16'hEE55, 1'b0, 8'hF0},
    {16'h178A, 1'b1, 8'h96}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, fp_i = 1'b0, mode_i = 1'b0;
  logic [NS-1:0] rx_i = '0;
  logic reg_we_i = 1'b0;
  logic [0:0] reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [NS-1:0] byte_vld_o;
  logic [NS*8-1:0] byte_data_o;
  logic [NS*CH_W-1:0] byte_chan_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tsi_rx_align #(.N_STREAMS(NS), .N_CHAN(NC)) i_tsi_rx_align (
    .clk_i, .rst_ni, .fp_i, .mode_i, .rx_i, .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .byte_vld_o, .byte_data_o, .byte_chan_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] pat, input int s, input int ch);
    return 8'(int'(pat) + s * 53 + ch * 29);
  endfunction

  task automatic write_reg(input logic [0:0] a, input logic [15:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = '0;
  endtask

  task automatic run_frame(input logic [15:0] cfg, input logic md, input logic [7:0] pat,
                           input int restart, input bit do_mid, input logic [15:0] mid_cfg,
                           input logic mid_md, input string req);
    int k[NS]; int slot[NS]; int errs[NS]; int nb[NS];
    int late;
    int base;
    late = 0; base = 0;
    for (int s = 0; s < NS; s++) begin
      k[s] = int'(cfg[4*s+1 +: 3]);
      slot[s] = ((cfg[4*s] ^ md) == 1'b0) ? 3 : 2;  // rising=3, falling=2
      errs[s] = 0; nb[s] = 0;
    end
    for (int e = 0; e < FRAME_CYC + 120 + restart; e++) begin
      @(negedge clk_i);
      if (e > 0 && !(restart > 0 && e - 1 < restart)) begin
        for (int s = 0; s < NS; s++) begin
          int rel; int l2; int b; bit ev;
          rel = e - 1 - base;
          l2 = rel - (k[s] + 1) - slot[s];
          b = (l2 >= 0) ? l2 / 4 : 0;
          ev = (l2 >= 0) && (l2 % 4 == 0) && (b % 8 == 7) && (b < 8 * NC);
          if (byte_vld_o[s] !== ev) begin
            if (rel >= FRAME_CYC + 12) late++;
            else errs[s]++;
          end else if (ev) begin
            nb[s]++;
            if (byte_data_o[s*8 +: 8] !== exp_byte(pat, s, b / 8) ||
                byte_chan_o[s*CH_W +: CH_W] !== CH_W'(b / 8)) errs[s]++;
          end
        end
      end
      fp_i = (e == 0) || (restart > 0 && e == restart);
      if (fp_i) base = e;
      reg_we_i = do_mid && (e == 100);
      if (reg_we_i) begin reg_wdata_i = mid_cfg; mode_i = mid_md; end
      for (int s = 0; s < NS; s++) begin
        int l;
        l = e - base - (k[s] + 1);
        if (restart > 0 && e < restart) rx_i[s] = 1'((e >> 1) + s);
        else if (l >= 0 && l < FRAME_CYC) begin
          logic [7:0] by; logic bv;
          by = exp_byte(pat, s, (l / 4) / 8);
          bv = by[7 - ((l / 4) % 8)];
          rx_i[s] = (l % 4 == slot[s]) ? bv : ~bv;
        end else rx_i[s] = 1'b0;
      end
    end
    @(negedge clk_i);
    fp_i = 1'b0; rx_i = '0; reg_we_i = 1'b0;
    for (int s = 0; s < NS; s++) begin
      check(errs[s] == 0, req, $sformatf("stream %0d misaligned bytes", s), errs[s], 0);
      check(nb[s] == NC, req, $sformatf("stream %0d byte count", s), nb[s], NC);
    end
    check(late == 0, "R8", "strobes after frame end", late, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int spur;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(reg_rdata_o == 16'h0, "R1", "rdata in reset", reg_rdata_o, 0);
    rst_ni = 1'b1;
    spur = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      rx_i = NS'(i * 5);
      if (byte_vld_o != '0) spur++;
    end
    rx_i = '0;
    check(spur == 0, "R1", "strobes before first pulse", spur, 0);
    check(reg_rdata_o == 16'h0, "R1", "rdata after reset", reg_rdata_o, 0);

    // R2: register access
    write_reg(1'b0, 16'hA5C3);
    check(reg_rdata_o == 16'hA5C3, "R2", "readback word 0", reg_rdata_o, 16'hA5C3);
    write_reg(1'b1, 16'hFFFF);
    reg_addr_i = 1'b1; #1;
    check(reg_rdata_o == 16'h0, "R2", "unused address read", reg_rdata_o, 0);
    reg_addr_i = 1'b0; #1;
    check(reg_rdata_o == 16'hA5C3, "R2", "word 0 after unused write", reg_rdata_o, 16'hA5C3);

    // table: every delay code, both edges, both modes (R3 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      write_reg(1'b0, VEC[v][24:9]);
      mode_i = VEC[v][8];
      run_frame(VEC[v][24:9], VEC[v][8], VEC[v][7:0], 0, 1'b0, 16'h0, 1'b0,
                VEC[v][8] ? "R3/R5/R6" : "R3/R4/R6");
    end

    // R7: mid-frame write and mode change deferred
    write_reg(1'b0, 16'h6420);
    mode_i = 1'b0;
    run_frame(16'h6420, 1'b0, 8'h77, 0, 1'b1, 16'h92D6, 1'b1, "R7 old cfg kept");
    run_frame(16'h92D6, 1'b1, 8'h19, 0, 1'b0, 16'h0, 1'b0, "R7 new cfg adopted");

    // R9: second pulse inside the frame restarts alignment
    write_reg(1'b0, 16'hFDB9);
    mode_i = 1'b0;
    run_frame(16'hFDB9, 1'b0, 8'hC4, 20, 1'b0, 16'h0, 1'b0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule